// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

This block sits between one processor core and a shared snooped bus. It holds a small direct-mapped write-back cache of one-word lines and keeps every line in one of three coherence states. The core's loads and stores are served from the cache when the line's state allows it. Otherwise the controller requests the bus, waits for the grant and issues exactly one bus command per granted cycle. That command is a read fill, an ownership broadcast that invalidates other copies, or a write-back of a dirty victim.

Every cycle the controller also watches the transactions that other caches place on the bus. A foreign write or ownership broadcast that hits a held line invalidates it. A foreign read that hits a dirty line makes this controller drive the snoop response and the line's data in the same cycle; memory then stays silent and takes the data. After that the line is clean and shared. Snoops always win over local work: while a snoop is present, no local access completes and no bus command fires.

Addresses are word addresses. The low `log2(LINES)` bits select the line and the rest form the tag. A bus transaction completes in the single cycle in which `bus_gnt` is high. Read data from memory or from an owning cache is presented on `bus_din` in that same cycle. The core holds its request stable until it sees `cpu_ack`.

Top module: `coh_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 2'b00), and `bus_req`, `cpu_ack` and `snp_resp` are low. The first access to any address therefore needs the bus.
- R2: A read whose line is Invalid or holds another tag raises `bus_req` with command 2'b01 and the request address. In the granted cycle it fills the line from `bus_din` in state Shared (2'b01), then acknowledges with that data.
- R3: A read that hits a Shared or Modified line acknowledges one cycle after the request is presented, without raising `bus_req`, and returns the line's data.
- R4: A write to a line that is not Modified with the same tag first broadcasts command 2'b10 with the request address. In the granted cycle it stores the data, sets the line Modified (2'b10) and acknowledges. A write that hits a Modified line completes locally in one cycle without the bus.
- R5: A snooped read (command 2'b01) that hits a Modified line asserts `snp_resp` combinationally in the same cycle, with the line's data on `snp_data`. The line then becomes Shared, so a later local write needs a new ownership broadcast.
- R6: A snoop with no effect leaves the cache unchanged and keeps `snp_resp` low. This covers a snooped read of a Shared line, and any snoop whose tag differs from the held line or whose line is Invalid.
- R7: A snooped ownership broadcast (2'b10) or write (2'b11) that hits a held line makes it Invalid, so the next local read of that address misses and fetches over the bus.
- R8: A miss whose line is Modified with a different tag first writes the victim back with command 2'b11, the victim's address and its data. Only after that does it issue the fill read or ownership broadcast for the new address.
- R9: While a snoop is present no local access completes and no bus command fires. The command a waiting request issues is chosen from the line state left after the snoop. For example, a dirty victim supplied to a snooped read needs no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Core access request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address of the access |
| cpu_wdata | input | DW | Store data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Load data, valid with `cpu_ack` |
| bus_req | output | 1 | Bus wanted for the command on `bus_cmd` |
| bus_gnt | input | 1 | Bus granted; the transaction happens in this cycle |
| bus_cmd | output | 2 | 01 read, 10 ownership broadcast, 11 write-back |
| bus_addr | output | AW | Address of the outgoing command |
| bus_dout | output | DW | Data of the outgoing command |
| bus_din | input | DW | Fill data during a granted read |
| snp_valid | input | 1 | A foreign transaction is on the bus |
| snp_cmd | input | 2 | Its command, same encoding as `bus_cmd` |
| snp_addr | input | AW | Its address |
| snp_resp | output | 1 | This cache supplies the data; memory must not |
| snp_data | output | DW | Supplied line data |

## Verification
The assertions watch the per-cycle rules on every cycle. A snoop response appears only for a snooped read of a dirty matching line, and the line reads Shared afterwards. A snooped invalidate or write that hits leaves the line Invalid. A store is acknowledged only while its line is Modified with the right tag, and a write-back is requested only for a dirty victim of another tag. No acknowledge follows a snoop cycle. The directed scenarios show what depends on whole sequences: the data actually returned after fills, supplies and invalidations, the exact order of write-back and fill on a conflict, and how a snoop arriving during a held grant changes the command that is finally issued.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_M = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'b00,
    BC_RD   = 2'b01,
    BC_INV  = 2'b10,
    BC_WB   = 2'b11
  } bus_cmd_e;
endpackage

// File: rtl/coh_array.sv
module coh_array
  import coh_pkg::*;
#(
  parameter int LINES = 8,
  parameter int TW    = 13,
  parameter int DW    = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(LINES)-1:0] ra_idx,
  output line_st_e                ra_st,
  output logic [TW-1:0]           ra_tag,
  output logic [DW-1:0]           ra_data,
  input  logic [$clog2(LINES)-1:0] rb_idx,
  output line_st_e                rb_st,
  output logic [TW-1:0]           rb_tag,
  output logic [DW-1:0]           rb_data,
  input  logic [$clog2(LINES)-1:0] w_idx,
  input  logic                    w_st_en,
  input  logic                    w_line_en,
  input  line_st_e                w_st,
  input  logic [TW-1:0]           w_tag,
  input  logic [DW-1:0]           w_data,
  output logic [2*LINES-1:0]      st_vec,
  output logic [TW*LINES-1:0]     tag_vec
);
  line_st_e          st_q   [LINES];
  logic [TW-1:0]     tag_q  [LINES];
  logic [DW-1:0]     data_q [LINES];

  assign ra_st   = st_q[ra_idx];
  assign ra_tag  = tag_q[ra_idx];
  assign ra_data = data_q[ra_idx];
  assign rb_st   = st_q[rb_idx];
  assign rb_tag  = tag_q[rb_idx];
  assign rb_data = data_q[rb_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else if (w_st_en || w_line_en) begin
      st_q[w_idx] <= w_st;
    end
  end

  always_ff @(posedge clk) begin
    if (w_line_en) begin
      tag_q[w_idx]  <= w_tag;
      data_q[w_idx] <= w_data;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_flat
    assign st_vec[2*g +: 2]   = st_q[g];
    assign tag_vec[TW*g +: TW] = tag_q[g];
  end
endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
  import coh_pkg::*;
#(
  parameter int TW = 13
) (
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [TW-1:0] snp_tag,
  input  line_st_e      l_st,
  input  logic [TW-1:0] l_tag,
  output logic          hit,
  output logic          supply,
  output logic          upd,
  output line_st_e      nxt_st
);
  logic kill_cmd;

  assign hit      = snp_valid && (l_st != ST_I) && (l_tag == snp_tag);
  assign kill_cmd = (snp_cmd == BC_INV) || (snp_cmd == BC_WB);
  assign supply   = hit && (snp_cmd == BC_RD) && (l_st == ST_M);
  assign upd      = supply || (hit && kill_cmd);
  assign nxt_st   = supply ? ST_S : ST_I;
endmodule

// File: rtl/coh_local.sv
module coh_local
  import coh_pkg::*;
#(
  parameter int TW = 13
) (
  input  logic          act,
  input  logic          we,
  input  logic [TW-1:0] req_tag,
  input  line_st_e      l_st,
  input  logic [TW-1:0] l_tag,
  output bus_cmd_e      cmd
);
  logic match;

  assign match = (l_st != ST_I) && (l_tag == req_tag);

  always_comb begin
    if (!act)                          cmd = BC_NONE;
    else if (l_st == ST_M && !match)   cmd = BC_WB;
    else if (!we)                      cmd = match ? BC_NONE : BC_RD;
    else                               cmd = (match && l_st == ST_M) ? BC_NONE : BC_INV;
  end
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LINES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ack,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_resp,
  output logic [DW-1:0] snp_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  function automatic logic [IW-1:0] idx_of(input logic [AW-1:0] a);
    return a[IW-1:0];
  endfunction

  function automatic logic [TW-1:0] tag_of(input logic [AW-1:0] a);
    return a[AW-1:IW];
  endfunction

  function automatic logic [AW-1:0] join_addr(input logic [TW-1:0] t, input logic [IW-1:0] i);
    return {t, i};
  endfunction

  // Named internal events
  line_st_e          loc_st, snp_st, snp_nxt, w_st;
  logic [TW-1:0]     loc_tag, snp_ltag, w_tag;
  logic [DW-1:0]     loc_data, w_data;
  logic [IW-1:0]     w_idx;
  logic              w_st_en, w_line_en;
  logic              act, snp_hit, snp_supply, snp_upd;
  logic              bus_fire, local_done;
  bus_cmd_e          need;
  logic [2*LINES-1:0]  st_vec;
  logic [TW*LINES-1:0] tag_vec;

  coh_array #(.LINES(LINES), .TW(TW), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(idx_of(cpu_addr)), .ra_st(loc_st), .ra_tag(loc_tag), .ra_data(loc_data),
    .rb_idx(idx_of(snp_addr)), .rb_st(snp_st), .rb_tag(snp_ltag), .rb_data(snp_data),
    .w_idx(w_idx), .w_st_en(w_st_en), .w_line_en(w_line_en),
    .w_st(w_st), .w_tag(w_tag), .w_data(w_data),
    .st_vec(st_vec), .tag_vec(tag_vec)
  );

  coh_snoop #(.TW(TW)) u_snp (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(tag_of(snp_addr)),
    .l_st(snp_st), .l_tag(snp_ltag),
    .hit(snp_hit), .supply(snp_supply), .upd(snp_upd), .nxt_st(snp_nxt)
  );

  assign act = cpu_req && !cpu_ack;

  coh_local #(.TW(TW)) u_loc (
    .act(act), .we(cpu_we), .req_tag(tag_of(cpu_addr)),
    .l_st(loc_st), .l_tag(loc_tag), .cmd(need)
  );

  assign snp_resp   = snp_supply;
  assign bus_req    = (need != BC_NONE);
  assign bus_cmd    = need;
  assign bus_addr   = (need == BC_WB) ? join_addr(loc_tag, idx_of(cpu_addr)) : cpu_addr;
  assign bus_dout   = (need == BC_WB) ? loc_data : cpu_wdata;
  assign bus_fire   = bus_req && bus_gnt && !snp_valid;
  assign local_done = act && (need == BC_NONE) && !snp_valid;

  // Single write port: snoop first, then bus completion, then local store
  always_comb begin
    w_idx     = idx_of(cpu_addr);
    w_st_en   = 1'b0;
    w_line_en = 1'b0;
    w_st      = ST_I;
    w_tag     = tag_of(cpu_addr);
    w_data    = cpu_wdata;
    if (snp_upd) begin
      w_idx   = idx_of(snp_addr);
      w_st_en = 1'b1;
      w_st    = snp_nxt;
    end else if (bus_fire) begin
      case (need)
        BC_WB:   begin w_st_en = 1'b1; w_st = ST_I; end
        BC_RD:   begin w_line_en = 1'b1; w_st = ST_S; w_data = bus_din; end
        default: begin w_line_en = 1'b1; w_st = ST_M; end
      endcase
    end else if (local_done && cpu_we) begin
      w_line_en = 1'b1;
      w_st      = ST_M;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ack <= local_done || (bus_fire && need == BC_INV);
      if (local_done) cpu_rdata <= cpu_we ? cpu_wdata : loc_data;
    end
  end
endmodule

// File: rtl/coh_ctrl_chk.sv
module coh_ctrl_chk #(
  parameter int AW    = 16,
  parameter int LINES = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cpu_ack,
  input logic                          cpu_we,
  input logic [AW-1:0]                 cpu_addr,
  input logic                          bus_req,
  input logic [1:0]                    bus_cmd,
  input logic                          snp_valid,
  input logic [1:0]                    snp_cmd,
  input logic [AW-1:0]                 snp_addr,
  input logic                          snp_resp,
  input logic [2*LINES-1:0]            st_vec,
  input logic [(AW-$clog2(LINES))*LINES-1:0] tag_vec
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  function automatic logic [1:0] st_at(input logic [2*LINES-1:0] v, input logic [IW-1:0] i);
    return v[2*i +: 2];
  endfunction

  function automatic logic [TW-1:0] tag_at(input logic [TW*LINES-1:0] v, input logic [IW-1:0] i);
    return v[TW*i +: TW];
  endfunction

  logic [IW-1:0] s_idx, c_idx;
  logic          s_match, c_match;
  assign s_idx   = snp_addr[IW-1:0];
  assign c_idx   = cpu_addr[IW-1:0];
  assign s_match = tag_at(tag_vec, s_idx) == snp_addr[AW-1:IW];
  assign c_match = tag_at(tag_vec, c_idx) == cpu_addr[AW-1:IW];

  a_r5_resp_only_dirty_read: assert property (@(posedge clk) disable iff (!rst_n)
    snp_resp |-> (snp_valid && snp_cmd == 2'b01 && st_at(st_vec, s_idx) == 2'b10 && s_match));

  a_r5_supply_leaves_shared: assert property (@(posedge clk) disable iff (!rst_n)
    snp_resp |=> st_at(st_vec, $past(s_idx)) == 2'b01);

  a_r7_snoop_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd[1] && s_match && st_at(st_vec, s_idx) != 2'b00)
      |=> st_at(st_vec, $past(s_idx)) == 2'b00);

  a_r4_store_owns_line: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_we) |-> (st_at(st_vec, c_idx) == 2'b10 && c_match));

  a_r8_wb_only_dirty_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 2'b11) |-> (st_at(st_vec, c_idx) == 2'b10 && !c_match));

  a_r9_snoop_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> !cpu_ack);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!cpu_ack && st_vec == '0));
endmodule

bind coh_ctrl coh_ctrl_chk #(.AW(AW), .LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ack(cpu_ack), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .bus_req(bus_req), .bus_cmd(bus_cmd), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_addr(snp_addr), .snp_resp(snp_resp), .st_vec(st_vec), .tag_vec(tag_vec)
);

// File: tb/sim_coh_ctrl.sv
`timescale 1ns/1ps
module sim_coh_ctrl;
  localparam int AW = 16, DW = 32, LINES = 8;
  localparam logic [1:0] C_RD = 2'b01, C_INV = 2'b10, C_WB = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, cpu_ack, bus_req, bus_gnt = 0, snp_valid = 0, snp_resp;
  logic [AW-1:0] cpu_addr = '0, bus_addr, snp_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata, bus_dout, bus_din = '0, snp_data;
  logic [1:0] bus_cmd, snp_cmd = '0;

  coh_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) u0 (.*);

  always #4 clk = ~clk;

  typedef struct { logic [1:0] c; logic [AW-1:0] a; logic [DW-1:0] d; } ent_t;
  ent_t lg[$];
  logic [DW-1:0] mem [int];
  bit hold_gnt = 0;
  int checks = 0, fails = 0;

  function automatic logic [DW-1:0] memrd(input logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : (32'hA000_0000 | 32'(a));
  endfunction

  // Bus model: arbiter plus memory
  always @(negedge clk) begin
    if (bus_gnt) bus_gnt <= 1'b0;
    else if (rst_n && bus_req && !hold_gnt && !snp_valid) begin
      lg.push_back('{bus_cmd, bus_addr, bus_dout});
      if (bus_cmd == C_WB) mem[int'(bus_addr)] = bus_dout;
      if (bus_cmd == C_RD) bus_din <= memrd(bus_addr);
      bus_gnt <= 1'b1;
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_ack && lat < 300);
    rd = cpu_rdata; cpu_req = 0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                       output bit resp, output logic [DW-1:0] d);
    @(negedge clk); #1;
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1; resp = snp_resp; d = snp_data;
    if (resp) mem[int'(a)] = d;
    @(negedge clk); #1 snp_valid = 0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] rd; int lat; bit r; logic [DW-1:0] d;
    chk("R1 bus_req idle", bus_req, 0);
    chk("R1 ack idle", cpu_ack, 0);
    snoop(C_RD, 16'h0005, r, d);
    chk("R1 no snoop resp on empty cache", r, 0);
    lg.delete();
    cpu_op(0, 16'h0002, 0, rd, lat);
    chk("R1 first read uses bus", lg.size(), 1);
    chk("R1 first read data", rd, memrd(16'h0002));
  endtask

  task automatic t_read;
    logic [DW-1:0] rd; int lat;
    lg.delete();
    cpu_op(0, 16'h0005, 0, rd, lat);
    chk("R2 one bus command", lg.size(), 1);
    chk("R2 command is read", lg[0].c, C_RD);
    chk("R2 read address", lg[0].a, 16'h0005);
    chk("R2 fill data", rd, 32'hA000_0005);
    lg.delete();
    cpu_op(0, 16'h0005, 0, rd, lat);
    chk("R3 hit uses no bus", lg.size(), 0);
    chk("R3 hit latency", lat, 1);
    chk("R3 hit data", rd, 32'hA000_0005);
  endtask

  task automatic t_write;
    logic [DW-1:0] rd; int lat;
    lg.delete();
    cpu_op(1, 16'h0005, 32'h1111_0001, rd, lat);
    chk("R4 shared write broadcasts", lg.size(), 1);
    chk("R4 broadcast command", lg[0].c, C_INV);
    chk("R4 broadcast address", lg[0].a, 16'h0005);
    lg.delete();
    cpu_op(1, 16'h0005, 32'h2222_0002, rd, lat);
    chk("R4 owned write no bus", lg.size(), 0);
    chk("R4 owned write latency", lat, 1);
    cpu_op(0, 16'h0005, 0, rd, lat);
    chk("R4 read back owned data", rd, 32'h2222_0002);
  endtask

  task automatic t_snoop_read;
    logic [DW-1:0] rd, d; int lat; bit r;
    snoop(C_RD, 16'h0005, r, d);
    chk("R5 dirty line responds", r, 1);
    chk("R5 supplied data", d, 32'h2222_0002);
    snoop(C_RD, 16'h0005, r, d);
    chk("R6 shared line silent", r, 0);
    snoop(C_INV, 16'h000D, r, d);
    chk("R6 other tag silent", r, 0);
    lg.delete();
    cpu_op(0, 16'h0005, 0, rd, lat);
    chk("R6 line kept after other-tag snoop", lg.size(), 0);
    chk("R5 shared after supply keeps data", rd, 32'h2222_0002);
    cpu_op(1, 16'h0005, 32'h3333_0003, rd, lat);
    chk("R5 write after supply rebroadcasts", lg.size(), 1);
  endtask

  task automatic t_snoop_kill;
    logic [DW-1:0] rd, d; int lat; bit r;
    snoop(C_INV, 16'h0005, r, d);
    chk("R7 invalidate no resp", r, 0);
    lg.delete();
    cpu_op(0, 16'h0005, 0, rd, lat);
    chk("R7 read after invalidate misses", lg.size(), 1);
    chk("R7 refetched data", rd, 32'h2222_0002);
    snoop(C_WB, 16'h0005, r, d);
    lg.delete();
    cpu_op(0, 16'h0005, 0, rd, lat);
    chk("R7 read after snooped write misses", lg.size(), 1);
  endtask

  task automatic t_evict;
    logic [DW-1:0] rd; int lat;
    cpu_op(1, 16'h0003, 32'hD0D0_0003, rd, lat);
    lg.delete();
    cpu_op(0, 16'h000B, 0, rd, lat);
    chk("R8 two commands", lg.size(), 2);
    chk("R8 write-back first", lg[0].c, C_WB);
    chk("R8 victim address", lg[0].a, 16'h0003);
    chk("R8 victim data", lg[0].d, 32'hD0D0_0003);
    chk("R8 then read", lg[1].c, C_RD);
    chk("R8 new line data", rd, 32'hA000_000B);
    chk("R8 memory updated", memrd(16'h0003), 32'hD0D0_0003);
    lg.delete();
    cpu_op(1, 16'h0013, 32'h1313_0013, rd, lat);
    chk("R8 clean victim no write-back", lg.size(), 1);
    lg.delete();
    cpu_op(0, 16'h0003, 0, rd, lat);
    chk("R8 dirty victim again", lg[0].c, C_WB);
    chk("R8 old data returns", rd, 32'hD0D0_0003);
  endtask

  task automatic t_wait_snoop;
    logic [DW-1:0] rd, d; int lat; bit r;
    cpu_op(1, 16'h0003, 32'hE0E0_0003, rd, lat);
    lg.delete();
    hold_gnt = 1;
    fork
      cpu_op(0, 16'h000B, 0, rd, lat);
      begin
        @(negedge clk); @(negedge clk); #1;
        chk("R9 waiting write-back", bus_cmd, C_WB);
        snoop(C_RD, 16'h0003, r, d);
        chk("R9 snoop served while waiting", r, 1);
        chk("R9 snoop data", d, 32'hE0E0_0003);
        #2 chk("R9 command re-chosen", bus_cmd, C_RD);
        chk("R9 no ack yet", cpu_ack, 0);
        hold_gnt = 0;
      end
    join
    chk("R9 only the read issued", lg.size(), 1);
    chk("R9 read data", rd, 32'hA000_000B);
    cpu_op(0, 16'h0006, 0, rd, lat);
    lg.delete();
    hold_gnt = 1;
    fork
      cpu_op(1, 16'h0006, 32'hF0F0_0006, rd, lat);
      begin
        @(negedge clk); @(negedge clk); #1;
        chk("R9 waiting broadcast", bus_cmd, C_INV);
        snoop(C_INV, 16'h0006, r, d);
        #2 chk("R9 still broadcast after kill", bus_cmd, C_INV);
        hold_gnt = 0;
      end
    join
    chk("R9 single broadcast", lg.size(), 1);
    lg.delete();
    cpu_op(0, 16'h0006, 0, rd, lat);
    chk("R9 store landed", rd, 32'hF0F0_0006);
    chk("R9 owned afterwards", lg.size(), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset(); t_read(); t_write(); t_snoop_read();
        t_snoop_kill(); t_evict(); t_wait_snoop();
      end
      begin
        repeat (150000) @(negedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule